// File: doc/BRIEF.md
# Accelerator Run Sequencer with Secure Wipe

This block is the control state machine of a small accelerator. A start pulse takes it from idle into a seeding phase. It waits there until the random seed reports ready. It then spends one cycle priming instruction fetch and enters execution. Execution ends when a halt request arrives. That request carries a 32-bit error vector and is accepted only during execution.

Every halt is followed by a wipe of fixed length. While the wipe runs, the rest of the accelerator clears its internal state. When the wipe ends, the block returns to idle after a clean halt. After a fatal halt it goes to a lock state, which only reset can leave. A halt is fatal when any error bit in the upper half of the vector is set.

The halt interface is a valid/ready pair. `halt_ready_o` is high only during execution. A halt transfers on a cycle where `halt_valid_i` and `halt_ready_o` are both high. At any other time `halt_valid_i` is ignored, so a requester that wants its halt taken must hold it until ready is seen. Start and seed-ready are plain level inputs sampled at each clock edge.

Top module: `accel_seq_ctrl`

## Requirements
- R1: After reset, `state_code_o` is 0. `busy_o`, `wipe_active_o`, `wipe_start_o`, `done_set_o` and `insn_cnt_clr_o` are all 0, and `err_bits_o` is 0.
- R2: `state_code_o` shows the following codes: idle 0, seeding 10, fetch-prime 11, executing 12, clean wipe 13, fatal wipe 14, locked 2550. `busy_o` is 1 for every code except 0 and 2550. `wipe_active_o` is 1 exactly for codes 13 and 14.
- R3: If `start_i` is high at a clock edge while idle, the next code is 10. If `start_i` is high in any other state, it has no effect.
- R4: Code 10 holds until `seed_ready_i` is high at an edge; the next code is then 11. Code 11 lasts exactly one cycle and is always followed by 12.
- R5: `halt_ready_o` is 1 only while the code is 12. A `halt_valid_i` seen while the code is not 12 changes neither the state nor the outputs.
- R6: An accepted halt with any of bits [31:16] of `halt_err_i` set moves to code 14. Any other accepted halt, including one with bits [15:0] all set, moves to code 13.
- R7: In the cycle after an accepted halt, `wipe_start_o` and `done_set_o` are both high for exactly one cycle. From that cycle on, `err_bits_o` shows the accepted error vector.
- R8: `insn_cnt_clr_o` pulses for one cycle together with `wipe_start_o`, but only for a fatal halt.
- R9: `wipe_en_i` is sampled when a halt is accepted. If it was 1, the wipe state lasts 98 cycles; if it was 0, the wipe state lasts 1 cycle.
- R10: A clean wipe ends in code 0 and a fatal wipe ends in code 2550. Code 2550 persists, ignoring `start_i`, until reset.
- R11: `err_bits_o` clears to 0 when a start is accepted and otherwise keeps its value, including through the wipe and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| seed_ready_i | input | 1 | Seed available; ends the seeding phase |
| halt_valid_i | input | 1 | Halt request valid |
| halt_ready_o | output | 1 | Halt can be accepted (executing) |
| halt_err_i | input | 32 | Error vector carried with the halt |
| wipe_en_i | input | 1 | Selects the full-length wipe for this halt |
| state_code_o | output | 12 | Numeric state code; code/10 gives the coarse status |
| busy_o | output | 1 | Run in progress |
| wipe_active_o | output | 1 | A wipe state is active |
| wipe_start_o | output | 1 | One-cycle pulse at the start of a wipe |
| done_set_o | output | 1 | One-cycle pulse that sets the done interrupt |
| insn_cnt_clr_o | output | 1 | One-cycle pulse that clears the instruction counter |
| err_bits_o | output | 32 | Error vector captured from the last halt |

## Verification
The hardest cases to reach are the exits of the full-length wipe. Reaching them takes a complete run: start, seed, fetch-prime and execute, then a halt with the wipe enabled. The stimulus then steps through all 98 wipe cycles one by one, checking each one, so that an off-by-one in the counter shows up on the exact cycle of the exit. The lock exit is confirmed by presenting start while locked, and the bench then resets mid-run to reach a second, clean full-length wipe. That wipe uses an error vector of 0x0000FFFF to probe the fatal boundary from below.

// File: rtl/accel_seq_pkg.sv
package accel_seq_pkg;
  localparam int CODE_W = 12;

  typedef enum logic [CODE_W-1:0] {
    ST_IDLE   = 12'd0,
    ST_SEED   = 12'd10,
    ST_PRIME  = 12'd11,
    ST_EXEC   = 12'd12,
    ST_WGOOD  = 12'd13,
    ST_WBAD   = 12'd14,
    ST_LOCKED = 12'd2550
  } seq_state_e;
endpackage

// File: rtl/accel_fatal_detect.sv
module accel_fatal_detect #(
  parameter int ERR_W     = 32,
  parameter int FATAL_LSB = 16
) (
  input  logic [ERR_W-1:0] err_i,
  output logic             fatal_o
);
  localparam int HI_W = ERR_W - FATAL_LSB;

  generate
    if (HI_W > 0) begin : g_hi
      assign fatal_o = |err_i[ERR_W-1:FATAL_LSB];
    end else begin : g_none
      assign fatal_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/accel_wipe_timer.sv
module accel_wipe_timer #(
  parameter int WIPE_LEN = 98
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  input  logic active_i,
  output logic expire_o
);
  localparam int CNT_W = (WIPE_LEN > 2) ? $clog2(WIPE_LEN) : 1;
  localparam logic [CNT_W-1:0] LONG_INIT = CNT_W'(WIPE_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= long_i ? LONG_INIT : '0;
    end else if (active_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/accel_halt_report.sv
module accel_halt_report #(
  parameter int ERR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_acc_i,
  input  logic             halt_acc_i,
  input  logic             fatal_i,
  input  logic [ERR_W-1:0] err_i,
  output logic [ERR_W-1:0] err_bits_o,
  output logic             wipe_start_o,
  output logic             done_set_o,
  output logic             clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_bits_o   <= '0;
      wipe_start_o <= 1'b0;
      done_set_o   <= 1'b0;
      clr_o        <= 1'b0;
    end else begin
      wipe_start_o <= halt_acc_i;
      done_set_o   <= halt_acc_i;
      clr_o        <= halt_acc_i && fatal_i;
      if (start_acc_i) begin
        err_bits_o <= '0;
      end else if (halt_acc_i) begin
        err_bits_o <= err_i;
      end
    end
  end
endmodule

// File: rtl/accel_seq_ctrl.sv
module accel_seq_ctrl
  import accel_seq_pkg::*;
#(
  parameter int ERR_W     = 32,
  parameter int FATAL_LSB = 16,
  parameter int WIPE_LEN  = 98
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              seed_ready_i,
  input  logic              halt_valid_i,
  output logic              halt_ready_o,
  input  logic [ERR_W-1:0]  halt_err_i,
  input  logic              wipe_en_i,
  output logic [CODE_W-1:0] state_code_o,
  output logic              busy_o,
  output logic              wipe_active_o,
  output logic              wipe_start_o,
  output logic              done_set_o,
  output logic              insn_cnt_clr_o,
  output logic [ERR_W-1:0]  err_bits_o
);
  seq_state_e state_q, state_d;
  logic start_acc, halt_acc, fatal, expire, in_wipe;

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign halt_acc  = halt_valid_i && (state_q == ST_EXEC);
  assign in_wipe   = (state_q == ST_WGOOD) || (state_q == ST_WBAD);

  accel_fatal_detect #(.ERR_W(ERR_W), .FATAL_LSB(FATAL_LSB)) fatal_i (
    .err_i   (halt_err_i),
    .fatal_o (fatal)
  );

  accel_wipe_timer #(.WIPE_LEN(WIPE_LEN)) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (halt_acc),
    .long_i   (wipe_en_i),
    .active_i (in_wipe),
    .expire_o (expire)
  );

  accel_halt_report #(.ERR_W(ERR_W)) report_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_acc_i  (start_acc),
    .halt_acc_i   (halt_acc),
    .fatal_i      (fatal),
    .err_i        (halt_err_i),
    .err_bits_o   (err_bits_o),
    .wipe_start_o (wipe_start_o),
    .done_set_o   (done_set_o),
    .clr_o        (insn_cnt_clr_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_acc) state_d = ST_SEED;
      ST_SEED:   if (seed_ready_i) state_d = ST_PRIME;
      ST_PRIME:  state_d = ST_EXEC;
      ST_EXEC:   if (halt_acc) state_d = fatal ? ST_WBAD : ST_WGOOD;
      ST_WGOOD:  if (expire) state_d = ST_IDLE;
      ST_WBAD:   if (expire) state_d = ST_LOCKED;
      ST_LOCKED: state_d = ST_LOCKED;
      default:   state_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_code_o  = state_q;
  assign busy_o        = (state_q != ST_IDLE) && (state_q != ST_LOCKED);
  assign wipe_active_o = in_wipe;
  assign halt_ready_o  = (state_q == ST_EXEC);
endmodule

// File: rtl/accel_seq_ctrl_chk.sv
module accel_seq_ctrl_chk #(
  parameter int ERR_W     = 32,
  parameter int FATAL_LSB = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             seed_ready_i,
  input logic             halt_valid_i,
  input logic             halt_ready_o,
  input logic [ERR_W-1:0] halt_err_i,
  input logic [11:0]      state_code_o,
  input logic             busy_o,
  input logic             wipe_active_o,
  input logic             wipe_start_o,
  input logic             done_set_o,
  input logic             insn_cnt_clr_o
);
  // R4
  prime_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_code_o == 12'd11 |=> state_code_o == 12'd12);
  // R4
  seed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_code_o == 12'd10 && !seed_ready_i) |=> state_code_o == 12'd10);
  // R10
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_code_o == 12'd2550 |=> state_code_o == 12'd2550);
  // R7
  wipe_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_start_o |=> !wipe_start_o);
  // R7
  done_with_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_o |-> (wipe_start_o && wipe_active_o));
  // R8
  clr_fatal_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_cnt_clr_o |-> state_code_o == 12'd14);
  // R3
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R6
  fatal_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_valid_i && halt_ready_o && (|halt_err_i[ERR_W-1:FATAL_LSB]))
      |=> state_code_o == 12'd14);
endmodule

bind accel_seq_ctrl accel_seq_ctrl_chk #(.ERR_W(ERR_W), .FATAL_LSB(FATAL_LSB)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .seed_ready_i   (seed_ready_i),
  .halt_valid_i   (halt_valid_i),
  .halt_ready_o   (halt_ready_o),
  .halt_err_i     (halt_err_i),
  .state_code_o   (state_code_o),
  .busy_o         (busy_o),
  .wipe_active_o  (wipe_active_o),
  .wipe_start_o   (wipe_start_o),
  .done_set_o     (done_set_o),
  .insn_cnt_clr_o (insn_cnt_clr_o)
);

// File: tb/accel_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module accel_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, seed = 1'b0, hv = 1'b0, wen = 1'b0;
  logic [31:0] herr = '0;
  logic        hready, busy, wact, wstart, done, clr;
  logic [11:0] code;
  logic [31:0] errq;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [11:0] code;
    logic        ws;
    logic        dn;
    logic        clr;
    logic [31:0] err;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  accel_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_ready_i(seed),
    .halt_valid_i(hv), .halt_ready_o(hready), .halt_err_i(herr),
    .wipe_en_i(wen), .state_code_o(code), .busy_o(busy),
    .wipe_active_o(wact), .wipe_start_o(wstart), .done_set_o(done),
    .insn_cnt_clr_o(clr), .err_bits_o(errq)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle, 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      exp_t e;
      logic eb, ea;
      e  = sb_q.pop_front();
      eb = (e.code != 12'd0) && (e.code != 12'd2550);  // R2
      ea = (e.code == 12'd13) || (e.code == 12'd14);   // R2
      check(code == e.code, e.tag, "state_code", {20'd0, code}, {20'd0, e.code});
      check(busy == eb && wact == ea && hready == (e.code == 12'd12), e.tag,
            "busy/active/ready", {29'd0, busy, wact, hready},
            {29'd0, eb, ea, (e.code == 12'd12)});
      check(wstart == e.ws && done == e.dn && clr == e.clr, e.tag, "pulses",
            {29'd0, wstart, done, clr}, {29'd0, e.ws, e.dn, e.clr});
      check(errq == e.err, e.tag, "err_bits", errq, e.err);
    end
  end

  // driver: apply inputs for one edge and queue the expected result
  task automatic cyc(input logic st, input logic sd, input logic v,
                     input logic [31:0] er, input logic we,
                     input logic [11:0] ecode, input logic ews, input logic edn,
                     input logic eclr, input logic [31:0] eerr, input string tag);
    exp_t e;
    @(negedge clk);
    start = st; seed = sd; hv = v; herr = er; wen = we;
    e.code = ecode; e.ws = ews; e.dn = edn; e.clr = eclr; e.err = eerr; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle_step(input logic [11:0] ecode, input logic [31:0] eerr,
                           input string tag);
    cyc(0, 0, 0, 32'd0, 0, ecode, 0, 0, 0, eerr, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    start = 0; seed = 0; hv = 0; herr = '0; wen = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(code == 12'd0 && !busy && !wact, "R1", "reset state",
          {20'd0, code}, 32'd0);
    check(!wstart && !done && !clr && errq == 32'd0, "R1", "reset outputs",
          errq, 32'd0);
  endtask

  // bring the block from idle to executing; err register cleared on start
  task automatic to_exec();
    cyc(1, 0, 0, 32'd0, 0, 12'd10, 0, 0, 0, 32'd0, "R3 start->seed R11 clear");
    cyc(0, 1, 0, 32'd0, 0, 12'd11, 0, 0, 0, 32'd0, "R4 seed ready");
    idle_step(12'd12, 32'd0, "R4 prime one cycle");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();

    // halt while idle is ignored (R5)
    cyc(0, 0, 1, 32'hFFFF_0000, 1, 12'd0, 0, 0, 0, 32'd0, "R5 halt ignored idle");

    // clean run, short wipe
    cyc(1, 0, 0, 32'd0, 0, 12'd10, 0, 0, 0, 32'd0, "R3 start");
    idle_step(12'd10, 32'd0, "R4 seed hold");
    cyc(1, 0, 0, 32'd0, 0, 12'd10, 0, 0, 0, 32'd0, "R3 start ignored in seed");
    cyc(0, 0, 1, 32'hFFFF_0000, 0, 12'd10, 0, 0, 0, 32'd0, "R5 halt ignored seed");
    cyc(0, 1, 0, 32'd0, 0, 12'd11, 0, 0, 0, 32'd0, "R4 seed->prime");
    idle_step(12'd12, 32'd0, "R4 prime->exec");
    idle_step(12'd12, 32'd0, "R5 exec holds");
    cyc(0, 0, 1, 32'h0000_00A5, 0, 12'd13, 1, 1, 0, 32'h0000_00A5, "R6 R7 clean halt");
    idle_step(12'd0, 32'h0000_00A5, "R9 short wipe R10 to idle R11 hold");
    idle_step(12'd0, 32'h0000_00A5, "R11 err held idle");

    // fatal run, long wipe
    to_exec();
    cyc(0, 0, 1, 32'h0001_0000, 1, 12'd14, 1, 1, 1, 32'h0001_0000, "R6 R8 fatal halt");
    for (int i = 0; i < 97; i++)
      idle_step(12'd14, 32'h0001_0000, "R9 long fatal wipe");
    idle_step(12'd2550, 32'h0001_0000, "R10 locked");
    cyc(1, 0, 0, 32'd0, 0, 12'd2550, 0, 0, 0, 32'h0001_0000, "R10 start ignored locked");
    idle_step(12'd2550, 32'h0001_0000, "R10 locked stays");
    @(negedge clk);

    // reset leaves lock
    do_reset();

    // boundary: lower half full is not fatal, long wipe
    to_exec();
    cyc(0, 0, 1, 32'h0000_FFFF, 1, 12'd13, 1, 1, 0, 32'h0000_FFFF, "R6 boundary clean");
    for (int i = 0; i < 97; i++)
      idle_step(12'd13, 32'h0000_FFFF, "R9 long clean wipe");
    idle_step(12'd0, 32'h0000_FFFF, "R10 clean long exit");

    // top bit fatal, short wipe
    to_exec();
    cyc(0, 0, 1, 32'h8000_0000, 0, 12'd14, 1, 1, 1, 32'h8000_0000, "R6 R8 top bit fatal");
    idle_step(12'd2550, 32'h8000_0000, "R9 short fatal wipe R10");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule